// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

The unit gathers eight event sources from a serial flash controller into one active-high interrupt line. Each source may arrive as a single-cycle pulse or as a level. A raw status register latches every event. A mask register selects which latched events may raise the interrupt. A masked status view shows the latched events that are enabled. A write-one-to-clear register removes latched events.

Software reaches the four registers through a small register port. The port has a write strobe, a 2-bit register select, write data and a combinational read data output. Register select 0 is raw status, 1 is the mask, 2 is masked status and 3 is the clear register. All four registers use the same bit assignment:

| Bit | Event |
|-----|-------|
| 0 | receive FIFO full |
| 1 | receive underflow |
| 2 | transmit overflow |
| 3 | transmit FIFO empty |
| 4 | transfer finished |
| 5 | bus error |
| 6 | protocol error |
| 7 | DMA done |

A latched event stays visible at select 0 while it is masked. It leaves only through an explicit clear.

Top module: `isu_irq_status`

## Requirements
- R1: After reset, raw status reads 0, the mask reads all ones, masked status reads 0 and `irq_o` is 0.
- R2: An event on `evt_i[i]` in a cycle sets raw bit i from the next cycle on, whatever the mask holds. The bit order is 0 receive full, 1 receive underflow, 2 transmit overflow, 3 transmit empty, 4 transfer finished, 5 bus error, 6 protocol error, 7 DMA done.
- R3: A write to select 1 loads the mask. A mask bit of 1 disables its source and a mask bit of 0 enables it. The mask reads back at select 1 and changes on no other write.
- R4: Select 2 reads the raw bits whose mask bit is 0.
- R5: Writing to select 3 clears each raw bit whose write-data bit is 1 and leaves the other raw bits unchanged. Writing all ones clears every pending event.
- R6: An event that arrives in the same cycle as a clear of the same bit wins, and the bit stays set. A source held high stays latched through any clear.
- R7: `irq_o` is active high and equals the OR of the masked status bits.
- R8: Writes to select 0 and select 2 have no effect on any register. Select 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Event sources, pulse or level |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 raw, 1 mask, 2 masked status, 3 clear |
| wdata_i | input | NUM_SRC | Register write data |
| rdata_o | output | NUM_SRC | Read data for the selected register (combinational) |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The bench raises events while their sources are masked, then unmasks them. A design that dropped masked events would show nothing in raw status and no interrupt after unmasking.

It clears one bit while an event on the same bit arrives, and it holds a source high through a clear. A design that gave the clear priority would lose that event.

It clears a subset of bits and writes to the read-only selects. A design that cleared bits it was not told to clear, or that accepted writes at selects 0 or 2, would change raw status or the mask.

It also checks the interrupt with a masked event pending. An inverted mask polarity would assert `irq_o` while every source is disabled.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned ISU_NUM_SRC = 8;
  localparam int unsigned ISU_SEL_W   = 2;

  typedef enum logic [ISU_SEL_W-1:0] {
    SEL_RAW   = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_MSTAT = 2'd2,
    SEL_CLR   = 2'd3
  } isu_sel_e;

  localparam int unsigned EV_RX_FULL   = 0;
  localparam int unsigned EV_RX_UNDER  = 1;
  localparam int unsigned EV_TX_OVER   = 2;
  localparam int unsigned EV_TX_EMPTY  = 3;
  localparam int unsigned EV_XFER_DONE = 4;
  localparam int unsigned EV_BUS_ERR   = 5;
  localparam int unsigned EV_PROTO_ERR = 6;
  localparam int unsigned EV_DMA_DONE  = 7;
endpackage

// File: rtl/isu_mask_reg.sv
module isu_mask_reg #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] mask_o
);
  // reset leaves every source disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_o <= '1;
    else if (load_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/isu_raw_bank.sv
module isu_raw_bank #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] raw_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       raw_o[g] <= 1'b0;
      else if (evt_i[g]) raw_o[g] <= 1'b1;  // event beats clear
      else if (clr_i[g]) raw_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/isu_read_mux.sv
module isu_read_mux
  import isu_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  isu_sel_e           sel_i,
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0] mstat_i,
  output logic [NUM_SRC-1:0] rdata_o
);
  always_comb begin
    unique case (sel_i)
      SEL_RAW:   rdata_o = raw_i;
      SEL_MASK:  rdata_o = mask_i;
      SEL_MSTAT: rdata_o = mstat_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/isu_irq_status.sv
module isu_irq_status
  import isu_pkg::*;
#(
  parameter int unsigned NUM_SRC = ISU_NUM_SRC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   evt_i,
  input  logic                 we_i,
  input  logic [ISU_SEL_W-1:0] addr_i,
  input  logic [NUM_SRC-1:0]   wdata_i,
  output logic [NUM_SRC-1:0]   rdata_o,
  output logic                 irq_o
);
  isu_sel_e           sel;
  logic               mask_ld;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] raw_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mstat;

  assign sel     = isu_sel_e'(addr_i);
  assign mask_ld = we_i && (sel == SEL_MASK);
  assign clr_vec = (we_i && (sel == SEL_CLR)) ? wdata_i : '0;
  assign mstat   = raw_q & ~mask_q;
  assign irq_o   = |mstat;

  isu_mask_reg #(.NUM_SRC(NUM_SRC)) i_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (mask_ld),
    .wdata_i (wdata_i),
    .mask_o  (mask_q)
  );

  isu_raw_bank #(.NUM_SRC(NUM_SRC)) i_raw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (clr_vec),
    .raw_o  (raw_q)
  );

  isu_read_mux #(.NUM_SRC(NUM_SRC)) i_rmux (
    .sel_i   (sel),
    .raw_i   (raw_q),
    .mask_i  (mask_q),
    .mstat_i (mstat),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/isu_irq_status_chk.sv
module isu_irq_status_chk #(
  parameter int unsigned NUM_SRC = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               we_i,
  input logic [1:0]         addr_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] raw_q,
  input logic [NUM_SRC-1:0] mask_q
);
  logic [NUM_SRC-1:0] clr_req;
  assign clr_req = (we_i && addr_i == 2'd3) ? wdata_i : '0;

  AST_EVT_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(evt_i)) == $past(evt_i)));  // R2
  AST_RISE_NEEDS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(evt_i)) == '0));  // R2
  AST_FALL_NEEDS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~raw_q & $past(raw_q) & ~$past(clr_req)) == '0));  // R5
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 2'd1) |=> $stable(mask_q));  // R3
  AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(raw_q & ~mask_q)));  // R7
endmodule

bind isu_irq_status isu_irq_status_chk #(.NUM_SRC(NUM_SRC)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .evt_i   (evt_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .raw_q   (raw_q),
  .mask_q  (mask_q)
);

// File: tb/test_isu_irq_status.sv
module test_isu_irq_status;
  localparam int N = 8;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic         we_i = 1'b0;
  logic [1:0]   addr_i = 2'd0;
  logic [N-1:0] wdata_i = '0;
  logic [N-1:0] rdata_o;
  logic         irq_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  isu_irq_status #(.NUM_SRC(N)) i_isu_irq_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d, input logic [N-1:0] ev = '0);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d; evt_i = ev;
    @(negedge clk_i);
    we_i = 1'b0; evt_i = '0;
  endtask

  task automatic pulse(input logic [N-1:0] ev);
    @(negedge clk_i);
    evt_i = ev;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [N-1:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 raw", 2'd0, 8'h00);
    rd_chk("R1 mask", 2'd1, 8'hFF);
    rd_chk("R1 mstat", 2'd2, 8'h00);
    chk("R1 irq", N'(irq_o), N'(0));
  endtask

  task automatic t_masked_latch;
    pulse(8'h80);  // DMA done, bit 7, masked
    rd_chk("R2 raw masked evt", 2'd0, 8'h80);
    rd_chk("R4 mstat masked", 2'd2, 8'h00);
    chk("R7 irq masked", N'(irq_o), N'(0));
  endtask

  task automatic t_unmask;
    wr(2'd1, 8'h7F);
    rd_chk("R3 mask readback", 2'd1, 8'h7F);
    rd_chk("R4 mstat unmasked", 2'd2, 8'h80);
    chk("R7 irq unmasked", N'(irq_o), N'(1));
    wr(2'd1, 8'hFF);
    chk("R3 remask irq", N'(irq_o), N'(0));
    rd_chk("R3 raw kept", 2'd0, 8'h80);
    wr(2'd1, 8'h7F);
  endtask

  task automatic t_clear;
    pulse(8'h09);  // rx full bit 0, tx empty bit 3
    rd_chk("R2 raw bits 0,3", 2'd0, 8'h89);
    wr(2'd3, 8'h08);
    rd_chk("R5 partial clear", 2'd0, 8'h81);
    wr(2'd3, 8'hFF);
    rd_chk("R5 clear all", 2'd0, 8'h00);
    chk("R7 irq after clear", N'(irq_o), N'(0));
  endtask

  task automatic t_collide;
    pulse(8'h14);  // bits 2 and 4
    wr(2'd3, 8'h14, 8'h10);
    rd_chk("R6 event beats clear", 2'd0, 8'h10);
    @(negedge clk_i);
    evt_i = 8'h20;  // level on bus error
    wr(2'd3, 8'hFF, 8'h20);
    evt_i = 8'h20;
    wr(2'd3, 8'hFF, 8'h20);
    rd_chk("R6 level held", 2'd0, 8'h20);
    evt_i = '0;
    wr(2'd3, 8'hFF);
    rd_chk("R6 level gone", 2'd0, 8'h00);
  endtask

  task automatic t_readonly;
    pulse(8'h02);
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h00);
    rd_chk("R8 raw unchanged", 2'd0, 8'h02);
    rd_chk("R8 mask unchanged", 2'd1, 8'h7F);
    rd_chk("R8 clr reads 0", 2'd3, 8'h00);
    wr(2'd3, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_masked_latch();
    t_unmask();
    t_clear();
    t_collide();
    t_readonly();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule